// File: doc/BRIEF.md
# Vectored Interrupt Controller with Spurious Detection

This block collects interrupt requests for a processor core and presents them on two active-low request lines. One line is for normal interrupts and one is for the fast interrupt. Source 0 is the fast source. Source 1 is a software-only source. Sources 2 and up come from external inputs. Each source has its own trigger mode, a priority and a stored handler vector.

Software takes a normal interrupt by reading the IRQ vector register. That read returns the vector of the winning source and quiets the IRQ line until an end-of-interrupt write. The fast source is taken by reading the FIQ vector register.

Either vector read can find nothing valid to hand out. This happens when a level input has dropped, when a source was disabled while its request was being taken, or when the read is simply stray. In that case the block returns a programmable spurious vector. It then holds both request lines inactive until software writes end-of-interrupt. Software can also force edge-mode sources pending, or clear them, through command registers.

The register port uses plain read and write strobes. Read data appears on `rdata` one cycle after `rd_en`. Address bits [5:4] select a page: 0 for the mode registers, 1 for the vector registers, 2 for the commands. Bits [3:0] give the source or command number. The command numbers are:

| Number | Command | Access |
|---|---|---|
| 0 | enable-set | write |
| 1 | enable-clear | write |
| 2 | pending-set | write |
| 3 | pending-clear | write |
| 4 | end-of-interrupt | write |
| 5 | spurious vector | read and write |
| 6 | IRQ vector | read |
| 7 | FIQ vector | read |
| 8 | raw pending | read |
| 9 | enable mask | read |

Top module: `irq_vec_ctrl`

## Requirements
- R1: A mode register holds the trigger code in bits [1:0]: 0 rising edge, 1 falling edge, 2 high level, 3 low level. An edge-mode source becomes pending on its matching input edge and stays pending until something clears it.
- R2: A level-mode source shows as pending only while its input holds its active level. This holds for one cycle of input sampling.
- R3: A one in a pending-set write makes the matching edge-mode source pending. A one in a pending-clear write clears it. Both writes leave level-mode sources unchanged.
- R4: Source 1 has no input pin. It becomes pending only through pending-set and is served like any other normal source.
- R5: An IRQ vector read returns the stored vector of the enabled, pending normal source (index 1 and up) with the largest priority. The priority is mode-register bits [6:4]. When priorities are equal, the lower index wins.
- R6: A vector read that serves an edge-mode source clears that source's pending bit. A level-mode source stays pending while its input is active.
- R7: Enable-set and enable-clear are write-one-to-set and write-one-to-clear views of one enable mask, which reads back as a register. Raw pending shows pending bits whether or not the source is enabled. Disabled sources do not drive the request lines.
- R8: `nirq` is low while an enabled normal source is pending. It goes high after a serving IRQ vector read and stays high until end-of-interrupt.
- R9: Only source 0 drives `nfiq`. A FIQ vector read while source 0 is enabled and pending returns source 0's vector.
- R10: An IRQ vector read with no enabled normal source pending returns the spurious vector.
- R11: A FIQ vector read with source 0 not enabled and pending returns the spurious vector.
- R12: After a spurious read, `nirq` and `nfiq` both stay high, even with sources pending, until end-of-interrupt is written.
- R13: After reset both request lines are high, the enable mask is 0 and no edge-mode source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fiq_in | input | 1 | Input of source 0 (fast) |
| src_in | input | NSRC-2 | Inputs of sources 2..NSRC-1 (bit k is source k) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register address: page in [5:4], number in [3:0] |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid the cycle after rd_en |
| nirq | output | 1 | Active-low normal interrupt request |
| nfiq | output | 1 | Active-low fast interrupt request |

## Verification
The embedded properties check these behaviours on every cycle:
- Forcing an edge source makes it pending, and acknowledging it clears it.
- The arbiter's winner is always a requesting source.
- A serving IRQ read quiets `nirq`.
- A spurious read returns the spurious vector and quiets both lines until end-of-interrupt.
- A valid FIQ read returns source 0's vector.

Some behaviours need the bench's scenarios instead:
- the priority order with ties
- rising against falling edge detection
- level sources that ignore the force commands and drop before the read
- a disabled source that is still visible in raw pending
- the order in which successive reads drain several pending sources

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   typedef enum logic [1:0] {
      TRIG_RISE = 2'd0,
      TRIG_FALL = 2'd1,
      TRIG_HIGH = 2'd2,
      TRIG_LOW  = 2'd3
   } trig_e;

   localparam int unsigned ADDR_W = 6;

   localparam logic [1:0] PAGE_MODE = 2'd0;
   localparam logic [1:0] PAGE_VEC  = 2'd1;
   localparam logic [1:0] PAGE_CMD  = 2'd2;

   localparam logic [3:0] CMD_EN_SET   = 4'd0;
   localparam logic [3:0] CMD_EN_CLR   = 4'd1;
   localparam logic [3:0] CMD_PEND_SET = 4'd2;
   localparam logic [3:0] CMD_PEND_CLR = 4'd3;
   localparam logic [3:0] CMD_EOI      = 4'd4;
   localparam logic [3:0] CMD_SPUR_VEC = 4'd5;
   localparam logic [3:0] CMD_IRQ_VEC  = 4'd6;
   localparam logic [3:0] CMD_FIQ_VEC  = 4'd7;
   localparam logic [3:0] CMD_PEND_RAW = 4'd8;
   localparam logic [3:0] CMD_EN_MASK  = 4'd9;
endpackage

// File: rtl/ivc_source.sv
module ivc_source
   import ivc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl_i,
   input  logic [1:0] trig_i,
   input  logic       set_i,
   input  logic       clr_i,
   input  logic       ack_i,
   output logic       pend_o
);
   logic samp_q, prev_q, edge_q;
   logic is_edge, edge_hit, lvl_act;

   always_comb begin
      is_edge  = (trig_i == TRIG_RISE) || (trig_i == TRIG_FALL);
      edge_hit = (trig_i == TRIG_RISE) ? (samp_q & ~prev_q) : (~samp_q & prev_q);
      lvl_act  = (trig_i == TRIG_HIGH) ? samp_q : ~samp_q;
      pend_o   = is_edge ? edge_q : lvl_act;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= 1'b0;
         prev_q <= 1'b0;
         edge_q <= 1'b0;
      end else begin
         samp_q <= lvl_i;
         prev_q <= samp_q;
         if (!is_edge) edge_q <= 1'b0;
         else          edge_q <= (edge_q & ~clr_i & ~ack_i) | edge_hit | set_i;
      end
   end

   // R3: forcing an edge-mode source leaves it pending next cycle
   a_r3_set_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && is_edge) |=> (pend_o || !is_edge));

   // R6: an acknowledge with no new edge or force clears an edge-mode source
   a_r6_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && is_edge && !edge_hit && !set_i && $stable(trig_i)) |=> (!pend_o || !is_edge));
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
   parameter int unsigned N  = 8,
   parameter int unsigned PW = 3,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]    req_i,
   input  logic [N*PW-1:0] prio_i,
   output logic            hit_o,
   output logic [IW-1:0]   idx_o
);
   logic [PW-1:0] best;

   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      best  = '0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i] && (!hit_o || prio_i[i*PW +: PW] > best)) begin
            hit_o = 1'b1;
            best  = prio_i[i*PW +: PW];
            idx_o = IW'(i);
         end
      end
   end

   // R5: the chosen index always belongs to a requesting source
   always_comb begin
      if (hit_o) begin
         a_r5_winner_req: assert (req_i[idx_o]);
      end
   end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import ivc_pkg::*;
#(
   parameter int unsigned NSRC = 8,
   parameter int unsigned DW   = 32,
   parameter int unsigned PW   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fiq_in,
   input  logic [NSRC-1:2]     src_in,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DW-1:0]       wdata,
   output logic [DW-1:0]       rdata,
   output logic                nirq,
   output logic                nfiq
);
   localparam int unsigned IW = $clog2(NSRC);

   if (NSRC < 3 || NSRC > 16) begin : g_bad_nsrc
      $error("NSRC must lie in 3..16");
   end
   if (DW < NSRC || DW < PW + 4) begin : g_bad_dw
      $error("DW too narrow for the mask or mode fields");
   end
   if (PW < 1) begin : g_bad_pw
      $error("PW must be at least 1");
   end

   logic [1:0]       trig_q [NSRC];
   logic [PW-1:0]    prio_q [NSRC];
   logic [DW-1:0]    vec_q  [NSRC];
   logic [NSRC-1:0]  en_q;
   logic [DW-1:0]    spv_q;
   logic             busy_q, spur_q;
   logic [DW-1:0]    rdata_q;

   logic [1:0]       page;
   logic [3:0]       num;
   logic [IW-1:0]    sidx;
   logic             num_ok;
   logic             wr_cmd, rd_cmd;
   logic             wr_eoi, rd_irqv, rd_fiqv;
   logic [NSRC-1:0]  lvl_vec, pend, req, set_v, clr_v, ack_v;
   logic [NSRC*PW-1:0] prio_flat;
   logic             irq_hit, fiq_ok;
   logic [IW-1:0]    win;

   always_comb begin
      page    = addr[5:4];
      num     = addr[3:0];
      sidx    = num[IW-1:0];
      num_ok  = (32'(num) < NSRC);
      wr_cmd  = wr_en && (page == PAGE_CMD);
      rd_cmd  = rd_en && (page == PAGE_CMD);
      wr_eoi  = wr_cmd && (num == CMD_EOI);
      rd_irqv = rd_cmd && (num == CMD_IRQ_VEC);
      rd_fiqv = rd_cmd && (num == CMD_FIQ_VEC);
      set_v   = (wr_cmd && num == CMD_PEND_SET) ? wdata[NSRC-1:0] : '0;
      clr_v   = (wr_cmd && num == CMD_PEND_CLR) ? wdata[NSRC-1:0] : '0;
      lvl_vec = {src_in, 1'b0, fiq_in};
      req     = pend & en_q & ~NSRC'(1);
      fiq_ok  = pend[0] & en_q[0];
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign prio_flat[i*PW +: PW] = prio_q[i];
      if (i == 0) begin : g_fast
         assign ack_v[i] = rd_fiqv && fiq_ok;
      end else begin : g_norm
         assign ack_v[i] = rd_irqv && irq_hit && (win == IW'(i));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            trig_q[i] <= TRIG_RISE;
            prio_q[i] <= '0;
            vec_q[i]  <= '0;
         end else if (wr_en && num_ok && sidx == IW'(i)) begin
            if (page == PAGE_MODE) begin
               trig_q[i] <= wdata[1:0];
               prio_q[i] <= wdata[4 +: PW];
            end
            if (page == PAGE_VEC) vec_q[i] <= wdata;
         end
      end

      ivc_source u_src (
         .clk    (clk),
         .rst_n  (rst_n),
         .lvl_i  (lvl_vec[i]),
         .trig_i (trig_q[i]),
         .set_i  (set_v[i]),
         .clr_i  (clr_v[i]),
         .ack_i  (ack_v[i]),
         .pend_o (pend[i])
      );
   end

   ivc_arbiter #(.N(NSRC), .PW(PW)) u_arb (
      .req_i  (req),
      .prio_i (prio_flat),
      .hit_o  (irq_hit),
      .idx_o  (win)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         spv_q  <= '0;
         busy_q <= 1'b0;
         spur_q <= 1'b0;
      end else begin
         if (wr_cmd && num == CMD_EN_SET)   en_q  <= en_q | wdata[NSRC-1:0];
         if (wr_cmd && num == CMD_EN_CLR)   en_q  <= en_q & ~wdata[NSRC-1:0];
         if (wr_cmd && num == CMD_SPUR_VEC) spv_q <= wdata;
         if (wr_eoi) begin
            busy_q <= 1'b0;
            spur_q <= 1'b0;
         end
         if (rd_irqv) begin
            if (irq_hit) busy_q <= 1'b1;
            else         spur_q <= 1'b1;
         end
         if (rd_fiqv && !fiq_ok) spur_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en) begin
         rdata_q <= '0;
         case (page)
            PAGE_MODE: if (num_ok) begin
               rdata_q[1:0]      <= trig_q[sidx];
               rdata_q[4 +: PW]  <= prio_q[sidx];
            end
            PAGE_VEC:  if (num_ok) rdata_q <= vec_q[sidx];
            PAGE_CMD: begin
               case (num)
                  CMD_SPUR_VEC: rdata_q <= spv_q;
                  CMD_IRQ_VEC:  rdata_q <= irq_hit ? vec_q[win] : spv_q;
                  CMD_FIQ_VEC:  rdata_q <= fiq_ok ? vec_q[0] : spv_q;
                  CMD_PEND_RAW: rdata_q[NSRC-1:0] <= pend;
                  CMD_EN_MASK:  rdata_q[NSRC-1:0] <= en_q;
                  default:      rdata_q <= '0;
               endcase
            end
            default: rdata_q <= '0;
         endcase
      end
   end

   assign rdata = rdata_q;
   assign nirq  = ~(irq_hit & ~busy_q & ~spur_q);
   assign nfiq  = ~(fiq_ok & ~spur_q);

   // R8: a serving IRQ vector read quiets the normal request line
   a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_irqv && irq_hit) |=> nirq);

   // R10: an IRQ read with nothing valid returns the spurious vector
   a_r10_spur_vec: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_irqv && !irq_hit) |=> (rdata == $past(spv_q)));

   // R9: a valid FIQ read returns source 0's vector
   a_r9_fiq_vec: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fiqv && fiq_ok) |=> (rdata == $past(vec_q[0])));

   // R11: a FIQ read with no valid fast request returns the spurious vector
   a_r11_fiq_spur: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fiqv && !fiq_ok) |=> (rdata == $past(spv_q)));

   // R12: any spurious read silences both lines in the next cycle
   a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (((rd_irqv && !irq_hit) || (rd_fiqv && !fiq_ok)) && !wr_eoi) |=> (nirq && nfiq));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
   localparam int NSRC = 8;
   localparam int DW   = 32;

   localparam logic [5:0] A_EN_SET = 6'h20, A_EN_CLR = 6'h21, A_P_SET = 6'h22,
                          A_P_CLR = 6'h23, A_EOI = 6'h24, A_SPV = 6'h25,
                          A_IRQV = 6'h26, A_FIQV = 6'h27, A_PEND = 6'h28, A_ENM = 6'h29;
   localparam logic [31:0] SPV = 32'hDEAD_0000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic fiq_in = 1'b0;
   logic [NSRC-1:2] src_in = '0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [5:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic nirq, nfiq;

   int checks = 0, errors = 0;
   logic [31:0] exp_q[$];
   string tag_q[$];
   logic rd_go = 1'b0;

   always #5 clk = ~clk;

   irq_vec_ctrl #(.NSRC(NSRC), .DW(DW), .PW(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .fiq_in(fiq_in), .src_in(src_in),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .nirq(nirq), .nfiq(nfiq)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compares read data against the scoreboard queue
   always @(negedge clk) begin
      if (rd_go) begin
         rd_go = 1'b0;
         if (exp_q.size() > 0) chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(posedge clk);
      exp_q.push_back(exp); tag_q.push_back(tag); rd_go = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] vec(input int i);
      return 32'hA000_0000 + 32'(i * 16);
   endfunction

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R13 reset state
      chk(32'(nirq), 1, "R13 nirq after reset");
      chk(32'(nfiq), 1, "R13 nfiq after reset");
      rd(A_PEND, 0, "R13 pending after reset");
      rd(A_ENM, 0, "R13 enable mask after reset");

      for (int i = 0; i < NSRC; i++) wr(6'h10 + 6'(i), vec(i));
      wr(A_SPV, SPV);

      // R10 stray IRQ read, R12 lines held
      rd(A_IRQV, SPV, "R10 stray irq read");
      wr(A_EN_SET, 32'h01);
      wr(A_P_SET, 32'h01);
      chk(32'(nfiq), 1, "R12 nfiq held after spurious");
      wr(A_EOI, 0);
      chk(32'(nfiq), 0, "R9 nfiq low after eoi");
      rd(A_FIQV, vec(0), "R9 fiq vector");
      chk(32'(nfiq), 1, "R6 fiq edge pend cleared");
      rd(A_FIQV, SPV, "R11 fiq read without request");
      wr(A_EOI, 0);

      // R4 software source
      wr(A_EN_SET, 32'h02);
      wr(A_P_SET, 32'h02);
      chk(32'(nirq), 0, "R4 nirq from software source");
      rd(A_PEND, 32'h02, "R4 raw pending");
      rd(A_IRQV, vec(1), "R4 software vector");
      chk(32'(nirq), 1, "R8 nirq held after serve");
      rd(A_PEND, 0, "R6 edge pend cleared by read");
      wr(A_EOI, 0);

      // R5 priority with tie
      wr(6'h02, 32'h20);
      wr(6'h03, 32'h50);
      wr(6'h04, 32'h50);
      wr(A_EN_SET, 32'h1C);
      src_in[2] = 1'b1; src_in[3] = 1'b1; src_in[4] = 1'b1;
      idle(3);
      rd(A_PEND, 32'h1C, "R1 rising edges pending");
      rd(A_IRQV, vec(3), "R5 tie goes to lower index");
      wr(A_EOI, 0);
      rd(A_IRQV, vec(4), "R5 second of tie");
      wr(A_EOI, 0);
      rd(A_IRQV, vec(2), "R5 lowest priority last");
      wr(A_EOI, 0);
      rd(A_IRQV, SPV, "R10 all drained");
      wr(A_EOI, 0);
      src_in[2] = 1'b0; src_in[3] = 1'b0; src_in[4] = 1'b0;

      // R1 falling edge
      wr(6'h05, 32'h11);
      src_in[5] = 1'b1;
      idle(3);
      rd(A_PEND, 0, "R1 no pend on rise in falling mode");
      src_in[5] = 1'b0;
      idle(3);
      rd(A_PEND, 32'h20, "R1 falling edge pending");
      wr(A_P_CLR, 32'h20);
      rd(A_PEND, 0, "R3 clear command on edge source");

      // R2 level sources, R3 ignored forcing
      wr(6'h06, 32'h72);
      wr(6'h07, 32'h03);
      rd(A_PEND, 32'h80, "R2 low level pending");
      wr(A_P_CLR, 32'h80);
      rd(A_PEND, 32'h80, "R3 clear ignored on level");
      src_in[7] = 1'b1;
      idle(2);
      rd(A_PEND, 0, "R2 low level released");
      src_in[6] = 1'b1;
      wr(A_EN_SET, 32'h40);
      chk(32'(nirq), 0, "R8 nirq low on level source");
      chk(32'(nfiq), 1, "R9 normal source leaves nfiq");
      rd(A_IRQV, vec(6), "R5 level source vector");
      rd(A_PEND, 32'h40, "R6 level stays pending");
      chk(32'(nirq), 1, "R8 nirq high until eoi");
      wr(A_EOI, 0);
      chk(32'(nirq), 0, "R8 nirq back after eoi");
      src_in[6] = 1'b0;
      idle(2);
      chk(32'(nirq), 1, "R2 level dropped");
      rd(A_IRQV, SPV, "R10 level dropped before read");
      src_in[6] = 1'b1;
      idle(2);
      chk(32'(nirq), 1, "R12 nirq held after spurious");
      wr(A_EOI, 0);
      chk(32'(nirq), 0, "R12 nirq released by eoi");

      // R7 enable mask
      wr(A_EN_CLR, 32'h40);
      chk(32'(nirq), 1, "R7 disabled source silent");
      rd(A_PEND, 32'h40, "R7 raw pending while disabled");
      rd(A_ENM, 32'h1F, "R7 enable mask readback");
      rd(A_IRQV, SPV, "R10 disabled source spurious");
      wr(A_EOI, 0);
      src_in[6] = 1'b0;

      // R1 rising edge on fast input
      fiq_in = 1'b1;
      idle(3);
      chk(32'(nfiq), 0, "R1 fiq rising edge");
      rd(A_FIQV, vec(0), "R9 fiq vector from edge");
      chk(32'(nfiq), 1, "R6 fiq cleared by read");
      fiq_in = 1'b0;

      idle(3);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule